// File: doc/BRIEF.md
# Near Call and Return Stack Sequencer

This block carries out 16-bit near subroutine calls and near returns for an execution core. A call stores the address of the following instruction on the stack through a word-addressed memory port and then moves the instruction pointer to its target. The target is either the following-instruction address plus a signed 16-bit displacement, or a 16-bit value taken from a register operand. A return reads the saved instruction pointer back from the stack. It checks that pointer against the code-segment limit and, in its immediate form, releases an extra count of bytes from the stack.

The stack pointer is held in the block. During an operation it is changed only in a speculative copy, and that copy is committed at the end when the new instruction pointer is within the code-segment limit. When the limit check fails, the block raises a general-protection fault pulse with error code zero, and the architectural stack pointer and instruction pointer keep their values from before the operation. The stack-size input chooses between full 32-bit stack-pointer arithmetic and arithmetic on the low 16 bits only.

Top module: `nearxfer_stack_unit`

## Requirements
- R1: After reset, `sp_out` equals the `RESET_SP` parameter, `ip_out` is 0, and `busy`, `done`, `fault` and `mem_req` are all 0.
- R2: `op_kind` encodes 2'b00 relative call, 2'b01 register call, 2'b10 return and 2'b11 return with immediate. A call first writes `next_ip` (`mem_we`=1) at the word address of the stack pointer minus 2, and only then completes.
- R3: The target of a relative call is `next_ip + operand` modulo 2^16. The target of a register call is `reg_target`.
- R4: A return reads the word at the current stack pointer. On success, `ip_out` becomes the value read and the stack pointer grows by 2.
- R5: A target strictly greater than `cs_limit` produces a `fault` pulse and no `done`, and `sp_out` and `ip_out` stay unchanged. A target equal to the limit is accepted.
- R6: A return with immediate adds `operand` (unsigned) to the stack pointer after the 2-byte pop. With `ss_big`=1 the sum is taken over all 32 bits.
- R7: A call whose target fails the limit check leaves `sp_out` unchanged, although its stack write has already taken place.
- R8: `done` and `fault` are single-cycle pulses that never occur together, one per accepted operation. `busy` is high from the cycle after `op_valid` is accepted until the result pulse, and `op_valid` is ignored while `busy` is high.
- R9: With `ss_big`=0, all stack-pointer arithmetic and the stack address use only bits 15:0, which wrap modulo 2^16, and bits 31:16 of `sp_out` are preserved.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ready` is seen, and the operation waits for any number of cycles of memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Start an operation (accepted only when not busy) |
| op_kind | input | 2 | Operation code, see R2 |
| next_ip | input | 16 | Address of the following instruction |
| operand | input | 16 | Call displacement or return immediate |
| reg_target | input | 16 | Register value for a register call |
| cs_limit | input | 16 | Code-segment limit, captured at start |
| ss_big | input | 1 | Stack size: 1 selects 32-bit stack pointer arithmetic |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | General-protection fault pulse (error code 0) |
| ip_out | output | 16 | Architectural instruction pointer |
| sp_out | output | 32 | Committed stack pointer |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the stack access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the request |

## Verification
Calls are exercised with both target sources and with a displacement that wraps past 0xFFFF. These separate the adder from the register path and confirm that the write address comes from the decremented pointer. Returns are driven with saved values one above and exactly at the code-segment limit, which separates fault rollback from commit. Returns with immediate run in both stack sizes on a pointer whose upper half is nonzero, so a 32-bit sum can be told apart from a 16-bit wrap. Repeated pushes across zero, a slow memory and a stray start pulse during an operation probe the wrap, the wait states and the rule that a start is ignored while busy.

// File: rtl/nxs_pkg.sv
package nxs_pkg;

    localparam int IP_W = 16;
    localparam int SP_W = 32;

    typedef enum logic [1:0] {
        OP_CALL_REL = 2'b00,
        OP_CALL_IND = 2'b01,
        OP_RET      = 2'b10,
        OP_RET_IMM  = 2'b11
    } xfer_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PUSH   = 2'd1,
        ST_POP    = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

    typedef struct packed {
        xfer_op_e          op;
        logic [IP_W-1:0]   next_ip;
        logic [IP_W-1:0]   operand;
        logic [IP_W-1:0]   reg_tgt;
        logic [IP_W-1:0]   limit;
        logic              big;
    } xfer_req_t;

    // Add a delta to the stack pointer honouring the stack size bit.
    function automatic logic [SP_W-1:0] sp_add(input logic [SP_W-1:0] sp,
                                               input logic [SP_W-1:0] delta,
                                               input logic big);
        logic [IP_W-1:0] low;
        low = sp[IP_W-1:0] + delta[IP_W-1:0];
        return big ? (sp + delta) : {sp[SP_W-1:IP_W], low};
    endfunction

    function automatic logic is_call(input xfer_op_e op);
        return (op == OP_CALL_REL) || (op == OP_CALL_IND);
    endfunction

endpackage

// File: rtl/nxs_sp_calc.sv
module nxs_sp_calc
    import nxs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [SP_W-1:0]   sp_cur,
    input  logic              big,
    input  xfer_op_e          op,
    input  logic [IP_W-1:0]   imm,
    output logic [SP_W-1:0]   push_sp,
    output logic [SP_W-1:0]   pop_sp,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] pop_addr
);
    localparam logic [SP_W-1:0] WORD_BYTES = SP_W'(2);

    logic [SP_W-1:0] imm_ext;
    logic [SP_W-1:0] after_pop;
    logic [SP_W-1:0] push_eff;
    logic [SP_W-1:0] pop_eff;
    logic [SP_W-1:0] push_word;
    logic [SP_W-1:0] pop_word;

    always_comb begin
        imm_ext   = (op == OP_RET_IMM) ? SP_W'(imm) : '0;
        push_sp   = sp_add(sp_cur, -WORD_BYTES, big);
        after_pop = sp_add(sp_cur, WORD_BYTES, big);
        pop_sp    = sp_add(after_pop, imm_ext, big);
        // Effective byte address: only the low half counts for a small stack.
        push_eff  = big ? push_sp : {{(SP_W-IP_W){1'b0}}, push_sp[IP_W-1:0]};
        pop_eff   = big ? sp_cur  : {{(SP_W-IP_W){1'b0}}, sp_cur[IP_W-1:0]};
        push_word = push_eff >> 1;
        pop_word  = pop_eff >> 1;
        push_addr = push_word[ADDR_W-1:0];
        pop_addr  = pop_word[ADDR_W-1:0];
    end

    logic unused_word_bits;
    assign unused_word_bits = ^{push_word, pop_word};

endmodule

// File: rtl/nxs_target_unit.sv
module nxs_target_unit
    import nxs_pkg::*;
(
    input  xfer_req_t        req,
    input  logic [IP_W-1:0]  tgt,
    output logic [IP_W-1:0]  call_tgt,
    output logic             over_limit
);
    always_comb begin
        unique case (req.op)
            OP_CALL_IND: call_tgt = req.reg_tgt;
            default:     call_tgt = req.next_ip + req.operand;
        endcase
        over_limit = (tgt > req.limit);
    end
endmodule

// File: rtl/nxs_sequencer.sv
module nxs_sequencer
    import nxs_pkg::*;
#(
    parameter logic [SP_W-1:0] RESET_SP = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req_in,
    input  logic              mem_ready,
    input  logic [IP_W-1:0]   mem_rdata,
    input  logic [IP_W-1:0]   call_tgt,
    input  logic              over_limit,
    input  logic [SP_W-1:0]   push_sp,
    input  logic [SP_W-1:0]   pop_sp,
    output seq_state_e        state,
    output xfer_req_t         req_q,
    output logic [IP_W-1:0]   tgt_q,
    output logic [SP_W-1:0]   sp_q,
    output logic [IP_W-1:0]   ip_q,
    output logic              done,
    output logic              fault
);
    logic [SP_W-1:0] spec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            req_q  <= '0;
            tgt_q  <= '0;
            spec_q <= '0;
            sp_q   <= RESET_SP;
            ip_q   <= '0;
            done   <= 1'b0;
            fault  <= 1'b0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        if (is_call(req_in.op)) begin
                            spec_q <= push_sp;
                            state  <= ST_PUSH;
                        end else begin
                            state  <= ST_POP;
                        end
                    end
                end
                ST_PUSH: begin
                    if (mem_ready) begin
                        tgt_q <= call_tgt;
                        state <= ST_FINISH;
                    end
                end
                ST_POP: begin
                    if (mem_ready) begin
                        tgt_q  <= mem_rdata;
                        spec_q <= pop_sp;
                        state  <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    if (over_limit) begin
                        fault <= 1'b1;
                    end else begin
                        sp_q <= spec_q;
                        ip_q <= tgt_q;
                        done <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: result pulses are exclusive
    assert_done_fault_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R8: an accepted start makes the unit busy next cycle
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (state != ST_IDLE));

    // R5 / R7: a fault keeps the architectural state
    assert_fault_rollback_R5: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($stable(sp_q) && $stable(ip_q)));

    // R5: a committed pointer never lies beyond the captured limit
    assert_ip_in_limit_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (ip_q <= req_q.limit));

    // R9: small-stack operations keep the upper half
    assert_upper_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !req_q.big) |-> (sp_q[SP_W-1:IP_W] == $past(sp_q[SP_W-1:IP_W])));

endmodule

// File: rtl/nearxfer_stack_unit.sv
module nearxfer_stack_unit
    import nxs_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [31:0]      RESET_SP = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [15:0]       next_ip,
    input  logic [15:0]       operand,
    input  logic [15:0]       reg_target,
    input  logic [15:0]       cs_limit,
    input  logic              ss_big,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [15:0]       ip_out,
    output logic [31:0]       sp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ready
);
    seq_state_e        state;
    xfer_req_t         req_in, req_q, act_req;
    logic [IP_W-1:0]   tgt_q, call_tgt;
    logic              over_limit;
    logic [SP_W-1:0]   sp_q, push_sp, pop_sp;
    logic [IP_W-1:0]   ip_q;
    logic [ADDR_W-1:0] push_addr, pop_addr;
    logic              start;

    always_comb begin
        req_in.op      = xfer_op_e'(op_kind);
        req_in.next_ip = next_ip;
        req_in.operand = operand;
        req_in.reg_tgt = reg_target;
        req_in.limit   = cs_limit;
        req_in.big     = ss_big;
        act_req        = (state == ST_IDLE) ? req_in : req_q;
        start          = op_valid && (state == ST_IDLE);
    end

    nxs_sp_calc #(.ADDR_W(ADDR_W)) u_sp (
        .sp_cur    (sp_q),
        .big       (act_req.big),
        .op        (req_q.op),
        .imm       (req_q.operand),
        .push_sp   (push_sp),
        .pop_sp    (pop_sp),
        .push_addr (push_addr),
        .pop_addr  (pop_addr)
    );

    nxs_target_unit u_tgt (
        .req        (req_q),
        .tgt        (tgt_q),
        .call_tgt   (call_tgt),
        .over_limit (over_limit)
    );

    nxs_sequencer #(.RESET_SP(RESET_SP)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_in     (req_in),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .call_tgt   (call_tgt),
        .over_limit (over_limit),
        .push_sp    (push_sp),
        .pop_sp     (pop_sp),
        .state      (state),
        .req_q      (req_q),
        .tgt_q      (tgt_q),
        .sp_q       (sp_q),
        .ip_q       (ip_q),
        .done       (done),
        .fault      (fault)
    );

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_PUSH) || (state == ST_POP);
        mem_we    = (state == ST_PUSH);
        mem_addr  = (state == ST_PUSH) ? push_addr : pop_addr;
        mem_wdata = req_q.next_ip;
        ip_out    = ip_q;
        sp_out    = sp_q;
    end

    // R10: a pending request holds still until the memory answers
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                     $stable(mem_addr) && $stable(mem_wdata)));

    // R2: the stack access of a call is a write
    assert_call_writes_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && is_call(req_q.op)) |-> mem_we);

endmodule

// File: tb/sim_nearxfer_stack_unit.sv
`timescale 1ns/1ps
module sim_nearxfer_stack_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [15:0] next_ip = '0, operand = '0, reg_target = '0, cs_limit = 16'hFFFF;
    logic        ss_big = 1'b0;
    logic        busy, done, fault, mem_req, mem_we, mem_ready;
    logic [15:0] ip_out, mem_wdata, mem_rdata;
    logic [31:0] sp_out;
    logic [15:0] mem_addr;

    nearxfer_stack_unit #(.ADDR_W(16), .RESET_SP(32'h0000_0100)) u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .next_ip(next_ip), .operand(operand), .reg_target(reg_target),
        .cs_limit(cs_limit), .ss_big(ss_big), .busy(busy), .done(done),
        .fault(fault), .ip_out(ip_out), .sp_out(sp_out), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Stack memory model: 256 words, fixed latency in cycles.
    logic [15:0] mem_arr [0:255];
    int          lat = 1;
    int          wait_cnt = 0;
    int          wr_count = 0;
    logic [15:0] last_waddr = '0, last_wdata = '0;
    initial mem_ready = 1'b0;
    assign mem_rdata = mem_arr[mem_addr[7:0]];

    always @(negedge clk) begin
        if (mem_req && !mem_ready) begin
            wait_cnt = wait_cnt + 1;
            if (wait_cnt >= lat) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem_arr[mem_addr[7:0]] = mem_wdata;
                    last_waddr = mem_addr;
                    last_wdata = mem_wdata;
                    wr_count = wr_count + 1;
                end
            end
        end else begin
            mem_ready = 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Exclusivity monitor (R8)
    always @(negedge clk) begin
        if (!rst && done && fault) begin
            checks++;
            errors++;
            $display("FAIL R8: actual done=1 fault=1 expected not both");
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic run_op(input logic [1:0] k, input logic [15:0] nip, input logic [15:0] opd,
                          input logic [15:0] rt, input logic [15:0] lim, input logic big,
                          output logic got_done, output logic got_fault);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; next_ip = nip; operand = opd;
        reg_target = rt; cs_limit = lim; ss_big = big;
        @(negedge clk);
        op_valid = 1'b0;
        got_done = 1'b0; got_fault = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        got_done = done;
        got_fault = fault;
    endtask

    logic d, f;

    task automatic t_reset();
        check("R1 sp", sp_out, 32'h0000_0100);
        check("R1 ip", {16'h0, ip_out}, 32'h0);
        check("R1 flags", {28'h0, busy, done, fault, mem_req}, 32'h0);
    endtask

    task automatic t_calls();
        run_op(2'b00, 16'h1234, 16'h0010, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R3 rel done", {30'h0, d, f}, 32'h2);
        check("R3 rel ip", {16'h0, ip_out}, 32'h1244);
        check("R2 push sp", sp_out, 32'h0000_00FE);
        check("R2 push addr", {16'h0, last_waddr}, 32'h007F);
        check("R2 push data", {16'h0, last_wdata}, 32'h1234);
        run_op(2'b01, 16'h2222, 16'h0, 16'h4000, 16'hFFFF, 1'b0, d, f);
        check("R3 ind ip", {16'h0, ip_out}, 32'h4000);
        check("R2 ind sp", sp_out, 32'h0000_00FC);
        check("R2 ind addr", {16'h0, last_waddr}, 32'h007E);
    endtask

    task automatic t_returns();
        run_op(2'b10, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R4 ret1 ip", {16'h0, ip_out}, 32'h2222);
        check("R4 ret1 sp", sp_out, 32'h0000_00FE);
        run_op(2'b10, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R4 ret2 ip", {16'h0, ip_out}, 32'h1234);
        check("R4 ret2 sp", sp_out, 32'h0000_0100);
    endtask

    task automatic t_rel_wrap();
        run_op(2'b00, 16'hFFF0, 16'h0020, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R3 wrap ip", {16'h0, ip_out}, 32'h0010);
        run_op(2'b10, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R4 wrap ret ip", {16'h0, ip_out}, 32'hFFF0);
        check("R4 wrap ret sp", sp_out, 32'h0000_0100);
    endtask

    task automatic t_ret_limit();
        mem_arr[8'h80] = 16'h1000;
        run_op(2'b10, 16'h0, 16'h0, 16'h0, 16'h0FFF, 1'b0, d, f);
        check("R5 over flags", {30'h0, d, f}, 32'h1);
        check("R5 over sp", sp_out, 32'h0000_0100);
        check("R5 over ip", {16'h0, ip_out}, 32'hFFF0);
        mem_arr[8'h80] = 16'h0FFF;
        run_op(2'b10, 16'h0, 16'h0, 16'h0, 16'h0FFF, 1'b0, d, f);
        check("R5 equal flags", {30'h0, d, f}, 32'h2);
        check("R5 equal ip", {16'h0, ip_out}, 32'h0FFF);
        check("R5 equal sp", sp_out, 32'h0000_0102);
    endtask

    task automatic t_call_fault();
        int w0;
        w0 = wr_count;
        run_op(2'b00, 16'h0050, 16'h01B0, 16'h0, 16'h00FF, 1'b0, d, f);
        check("R7 flags", {30'h0, d, f}, 32'h1);
        check("R7 sp", sp_out, 32'h0000_0102);
        check("R7 ip", {16'h0, ip_out}, 32'h0FFF);
        check("R7 write done", wr_count - w0, 32'h1);
    endtask

    task automatic t_ret_imm();
        mem_arr[8'h81] = 16'h0300;
        run_op(2'b11, 16'h0, 16'hFFFE, 16'h0, 16'hFFFF, 1'b1, d, f);
        check("R6 big ip", {16'h0, ip_out}, 32'h0300);
        check("R6 big sp", sp_out, 32'h0001_0102);
        mem_arr[8'h81] = 16'h0400;
        run_op(2'b11, 16'h0, 16'hFF00, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R6 small ip", {16'h0, ip_out}, 32'h0400);
        check("R6 R9 small sp", sp_out, 32'h0001_0004);
    endtask

    task automatic t_push_wrap();
        run_op(2'b00, 16'h0500, 16'h0, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R9 step1 sp", sp_out, 32'h0001_0002);
        run_op(2'b00, 16'h0500, 16'h0, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R9 step2 sp", sp_out, 32'h0001_0000);
        run_op(2'b00, 16'h0500, 16'h0, 16'h0, 16'hFFFF, 1'b0, d, f);
        check("R9 wrap sp", sp_out, 32'h0001_FFFE);
        check("R9 wrap addr", {16'h0, last_waddr}, 32'h7FFF);
    endtask

    task automatic t_slow_busy();
        int w0;
        int n_done;
        w0 = wr_count;
        n_done = 0;
        lat = 6;
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b10; cs_limit = 16'hFFFF; ss_big = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        check("R8 busy", {31'h0, busy}, 32'h1);
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'b00; next_ip = 16'h7777; operand = 16'h0001;
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done) n_done++;
            @(negedge clk);
        end
        check("R8 one result", n_done, 32'h1);
        check("R8 stray ignored", wr_count - w0, 32'h0);
        check("R10 slow ip", {16'h0, ip_out}, 32'h0500);
        check("R10 slow sp", sp_out, 32'h0001_0000);
        check("R8 idle after", {31'h0, busy}, 32'h0);
        lat = 1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_calls();
        t_returns();
        t_rel_wrap();
        t_ret_limit();
        t_call_fault();
        t_ret_imm();
        t_push_wrap();
        t_slow_busy();
        finish_run();
    end

endmodule